// File: doc/BRIEF.md
# Shared-Memory Bus Phase Generator

This block runs from the pixel-rate clock (about 8 MHz) and produces the timing that lets a video fetcher and a CPU take turns on one memory. It keeps a horizontal and a vertical raster counter, takes the low three bits of the horizontal count as an eight-step phase, and derives two strobes from it. The memory strobe runs at a quarter of the pixel rate, giving two memory slots per CPU cycle. The CPU strobe keeps only the second of each pair of memory pulses, so its duty cycle is not 50%.

On character-fetch lines the video side also takes the CPU's memory slots in a fixed window of line cycles. The block raises a stall output over that window and holds the CPU strobe low for its length. A fetch line is found with a character-row tracker. The tracker is a three-state machine: `ROW_IDLE` (outside the text band, row 0), `ROW_FETCH` (inside the band, row 0 after the row count wraps) and `ROW_TEXT` (rows 1 to 7). It moves `ROW_IDLE -> ROW_TEXT` and `ROW_FETCH -> ROW_TEXT` at the row step point. It moves `ROW_TEXT -> ROW_FETCH` when row 7 steps over, and any state goes to `ROW_IDLE` when the vertical count leaves the band. The first line of the band is a fetch line while the tracker is still in `ROW_IDLE`.

Top module: `bus_phase_gen`

## Requirements
- R1: A synchronous reset, sampled on the clock edge, clears the horizontal count, the vertical count and the row tracker. While reset is held, both counts read 0.
- R2: The horizontal count steps by one on every clock from 0 to 503 and then returns to 0.
- R3: The vertical count changes only on the clock where the horizontal count goes from 503 to 0. There it steps by one, and it returns from 311 to 0.
- R4: `phase` equals horizontal count bits 2:0, and `line_cycle` equals horizontal count bits 8:3.
- R5: `mem_strobe` is 1 exactly when phase bit 1 is set (phases 2, 3, 6, 7).
- R6: Outside a stall, `cpu_strobe` is 1 exactly in phases 6 and 7. The first memory pulse of each CPU cycle (phases 2, 3) is dropped.
- R7: A line is a fetch line when the vertical count is from 56 to 254 inclusive and the row count is 0. The row count steps (mod 8) at horizontal count 384 and is held at 0 outside that band. This gives the fetch lines 56, 64, …, 248, which is 25 per frame.
- R8: `cpu_stall` is 1 for every clock of line cycles 4 to 43 (horizontal counts 32 to 351) on a fetch line, and 0 at every other time.
- R9: While `cpu_stall` is 1, `cpu_strobe` is 0. `mem_strobe` keeps its normal pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| raster_x | output | 9 | Horizontal raster count |
| raster_y | output | 9 | Vertical raster count |
| phase | output | 3 | Step within the CPU cycle |
| line_cycle | output | 6 | CPU cycle number within the line |
| mem_strobe | output | 1 | Memory slot strobe, two pulses per CPU cycle |
| cpu_strobe | output | 1 | CPU strobe, second memory pulse only, muted while stalled |
| cpu_stall | output | 1 | CPU blocked from memory on a fetch line |

## Verification
A slip in the horizontal count shows at once on `phase`, `line_cycle` and both strobes. An error in the vertical count shows only at the next line wrap. A row tracker that steps at the wrong point or misses a clear moves the stall window to the wrong lines. That is first visible at horizontal count 32 on the affected line, and it can stay hidden for up to eight lines. The bench therefore compares every output against a behavioural model on every clock across a whole frame, including both counter wraps. It also counts the stalled lines.

// File: rtl/bus_phase_pkg.sv
`timescale 1ns/1ps
package bus_phase_pkg;

    // Character-row tracker states
    typedef enum logic [1:0] {
        ROW_IDLE  = 2'd0,   // outside the text band, row count 0
        ROW_FETCH = 2'd1,   // inside the band, row count wrapped to 0
        ROW_TEXT  = 2'd2    // rows 1..7
    } row_state_e;

endpackage

// File: rtl/bus_raster_counter.sv
`timescale 1ns/1ps
module bus_raster_counter #(
    parameter int H_TOTAL = 504,
    parameter int V_TOTAL = 312,
    parameter int H_W     = 9,
    parameter int V_W     = 9
) (
    input  logic           clk,
    input  logic           rst,
    output logic [H_W-1:0] x,
    output logic [V_W-1:0] y
);
    localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
    localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

    logic h_wrap;
    assign h_wrap = (x == H_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
        end else if (h_wrap) begin
            x <= '0;
        end else begin
            x <= x + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (h_wrap) begin
            y <= (y == V_LAST) ? '0 : y + 1'b1;
        end
    end

    p_x_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (x == H_LAST) |=> (x == '0));
    p_x_step_r2: assert property (@(posedge clk) disable iff (rst)
        (x != H_LAST) |=> (x == $past(x) + 1'b1));
    p_y_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (x != H_LAST) |=> $stable(y));
    p_y_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (x == H_LAST && y == V_LAST) |=> (y == '0));
endmodule

// File: rtl/bus_row_tracker.sv
`timescale 1ns/1ps
module bus_row_tracker
    import bus_phase_pkg::*;
#(
    parameter int H_W          = 9,
    parameter int V_W          = 9,
    parameter int BAND_FIRST   = 56,
    parameter int BAND_LAST    = 254,
    parameter int ROW_STEP_X   = 384,
    parameter int ROWS_PER_CHR = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] x,
    input  logic [V_W-1:0] y,
    output logic           fetch_line
);
    localparam int ROW_W = $clog2(ROWS_PER_CHR);
    localparam logic [V_W-1:0]   Y_FIRST = V_W'(BAND_FIRST);
    localparam logic [V_W-1:0]   Y_LAST  = V_W'(BAND_LAST);
    localparam logic [H_W-1:0]   X_STEP  = H_W'(ROW_STEP_X);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS_PER_CHR - 1);

    row_state_e       state, state_n;
    logic [ROW_W-1:0] row, row_n;
    logic             in_band;
    logic             row_zero;

    assign in_band = (y >= Y_FIRST) && (y <= Y_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ROW_IDLE;
            row   <= '0;
        end else begin
            state <= state_n;
            row   <= row_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        row_n   = row;
        if (!in_band) begin
            state_n = ROW_IDLE;
            row_n   = '0;
        end else if (x == X_STEP) begin
            unique case (state)
                ROW_IDLE, ROW_FETCH: begin
                    state_n = ROW_TEXT;
                    row_n   = ROW_W'(1);
                end
                ROW_TEXT: begin
                    if (row == ROW_MAX) begin
                        state_n = ROW_FETCH;
                        row_n   = '0;
                    end else begin
                        row_n   = row + 1'b1;
                    end
                end
                default: begin
                    state_n = ROW_IDLE;
                    row_n   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ROW_IDLE, ROW_FETCH: row_zero = 1'b1;
            ROW_TEXT:            row_zero = 1'b0;
            default:             row_zero = 1'b0;
        endcase
    end

    assign fetch_line = in_band && row_zero;

    p_text_row_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ROW_TEXT) |-> (row != '0));
    p_idle_only_outside_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ROW_IDLE && row != '0) |-> 1'b0);
    p_fetch_in_band_r7: assert property (@(posedge clk) disable iff (rst)
        fetch_line |-> (y >= Y_FIRST && y <= Y_LAST));
endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen #(
    parameter int PHASE_W     = 3,
    parameter int CYC_W       = 6,
    parameter int STALL_FIRST = 4,
    parameter int STALL_LAST  = 43
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [CYC_W-1:0]   line_cycle,
    input  logic               fetch_line,
    output logic               mem_strobe,
    output logic               cpu_strobe,
    output logic               cpu_stall
);
    localparam logic [PHASE_W-1:0] CPU_GATE = PHASE_W'((1 << (PHASE_W - 1)) + 0);
    localparam logic [CYC_W-1:0]   C_FIRST  = CYC_W'(STALL_FIRST);
    localparam logic [CYC_W-1:0]   C_LAST   = CYC_W'(STALL_LAST);

    logic cpu_raw;

    assign mem_strobe = phase[1];
    // keep only the second memory pulse of each CPU cycle
    assign cpu_raw    = (phase > CPU_GATE) && phase[1];
    assign cpu_stall  = fetch_line && (line_cycle >= C_FIRST) && (line_cycle <= C_LAST);
    assign cpu_strobe = cpu_raw && !cpu_stall;
endmodule

// File: rtl/bus_phase_gen.sv
`timescale 1ns/1ps
module bus_phase_gen #(
    parameter int H_TOTAL     = 504,
    parameter int V_TOTAL     = 312,
    parameter int PHASE_W     = 3,
    parameter int BAND_FIRST  = 56,
    parameter int BAND_LAST   = 254,
    parameter int ROW_STEP_X  = 384,
    parameter int STALL_FIRST = 4,
    parameter int STALL_LAST  = 43,
    parameter int H_W         = $clog2(H_TOTAL),
    parameter int V_W         = $clog2(V_TOTAL),
    parameter int CYC_W       = H_W - PHASE_W
) (
    input  logic               clk,
    input  logic               rst,
    output logic [H_W-1:0]     raster_x,
    output logic [V_W-1:0]     raster_y,
    output logic [PHASE_W-1:0] phase,
    output logic [CYC_W-1:0]   line_cycle,
    output logic               mem_strobe,
    output logic               cpu_strobe,
    output logic               cpu_stall
);
    localparam int ROWS_PER_CHR = 1 << PHASE_W;

    logic fetch_line;

    bus_raster_counter #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_W(H_W), .V_W(V_W)
    ) u_raster (
        .clk(clk), .rst(rst), .x(raster_x), .y(raster_y)
    );

    assign phase      = raster_x[PHASE_W-1:0];
    assign line_cycle = raster_x[H_W-1:PHASE_W];

    bus_row_tracker #(
        .H_W(H_W), .V_W(V_W), .BAND_FIRST(BAND_FIRST), .BAND_LAST(BAND_LAST),
        .ROW_STEP_X(ROW_STEP_X), .ROWS_PER_CHR(ROWS_PER_CHR)
    ) u_rows (
        .clk(clk), .rst(rst), .x(raster_x), .y(raster_y), .fetch_line(fetch_line)
    );

    bus_strobe_gen #(
        .PHASE_W(PHASE_W), .CYC_W(CYC_W),
        .STALL_FIRST(STALL_FIRST), .STALL_LAST(STALL_LAST)
    ) u_strobe (
        .phase(phase), .line_cycle(line_cycle), .fetch_line(fetch_line),
        .mem_strobe(mem_strobe), .cpu_strobe(cpu_strobe), .cpu_stall(cpu_stall)
    );

    p_mem_follows_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PHASE_W'(1)) |=> mem_strobe);
    p_cpu_inside_mem_r6: assert property (@(posedge clk) disable iff (rst)
        cpu_strobe |-> mem_strobe);
    p_cpu_late_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_strobe) |-> (phase == PHASE_W'(6)));
    p_stall_opens_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> (line_cycle == CYC_W'(STALL_FIRST) && phase == '0));
    p_stall_closes_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_stall) |-> (line_cycle == CYC_W'(STALL_LAST + 1)));
    p_stall_mutes_cpu_r9: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && $past(cpu_stall)) |-> !cpu_strobe);
endmodule

// File: tb/bus_phase_gen_test.sv
`timescale 1ns/1ps
module bus_phase_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] raster_x, raster_y;
    logic [2:0] phase;
    logic [5:0] line_cycle;
    logic       mem_strobe, cpu_strobe, cpu_stall;

    integer checks = 0;
    integer failures = 0;
    bit     done = 0;

    // reference model state
    integer ex = 0, ey = 0, erow = 0;
    integer stall_lines = 0;
    integer last_stall_y = -1;

    always #2.5 clk = ~clk;

    bus_phase_gen uut (
        .clk(clk), .rst(rst), .raster_x(raster_x), .raster_y(raster_y),
        .phase(phase), .line_cycle(line_cycle), .mem_strobe(mem_strobe),
        .cpu_strobe(cpu_strobe), .cpu_stall(cpu_stall)
    );

    always @(posedge clk) begin
        if (rst) begin
            ex = 0; ey = 0; erow = 0;
        end else begin
            if (!(ey >= 56 && ey <= 254)) erow = 0;
            else if (ex == 384) erow = (erow + 1) % 8;
            if (ex == 503) begin
                ex = 0;
                ey = (ey == 311) ? 0 : ey + 1;
            end else begin
                ex = ex + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input integer act, input integer exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, ex, ey);
        end
    endtask

    task automatic compare_all();
        integer ph, cy, fetch, st, mem, cpu;
        ph    = ex % 8;
        cy    = ex / 8;
        fetch = (ey >= 56 && ey <= 254 && erow == 0) ? 1 : 0;
        st    = (fetch == 1 && cy >= 4 && cy <= 43) ? 1 : 0;
        mem   = (ph / 2) % 2;
        cpu   = (ph >= 6 && st == 0) ? 1 : 0;
        check(raster_x == ex[8:0], "R2 raster_x", raster_x, ex);
        check(raster_y == ey[8:0], "R3 raster_y", raster_y, ey);
        check(phase == ph[2:0], "R4 phase", phase, ph);
        check(line_cycle == cy[5:0], "R4 line_cycle", line_cycle, cy);
        check(mem_strobe == mem[0], "R5 mem_strobe", mem_strobe, mem);
        check(cpu_stall == st[0], "R7 R8 cpu_stall", cpu_stall, st);
        if (st == 1) check(cpu_strobe == 1'b0, "R9 cpu_strobe muted", cpu_strobe, 0);
        else         check(cpu_strobe == cpu[0], "R6 cpu_strobe", cpu_strobe, cpu);
        if (st == 1 && last_stall_y != ey) begin
            stall_lines++;
            last_stall_y = ey;
            check((ey - 56) % 8 == 0, "R7 stall line spacing", ey, 56 + ((ey - 56) / 8) * 8);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(raster_x == 9'd0 && raster_y == 9'd0, "R1 reset state", {raster_y, raster_x}, 0);
        rst = 1'b0;
        // one full frame plus both wraps
        for (int i = 0; i < 504 * 312 + 20; i++) begin
            @(negedge clk);
            compare_all();
        end
        check(stall_lines == 25, "R7 fetch lines per frame", stall_lines, 25);
        // reset in mid-line
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(raster_x == 9'd0 && raster_y == 9'd0, "R1 mid-run reset", {raster_y, raster_x}, 0);
        rst = 1'b0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            compare_all();
        end
        summary();
    end

    initial begin
        #(199000 * 5);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule